// File: doc/BRIEF.md
# Chainable Eight-Input Serializer Model

This block models one eight-channel digital input serializer that answers a host over a four-wire serial link and can be chained with copies of itself. Each channel passes through a filter whose settling time is picked by two select pins. When chip select falls, the filtered inputs are frozen into a shift register. The host then clocks them out most significant bit first, optionally followed by a diagnostic byte that carries a five-bit check code of the frozen inputs and three alarm flags.

After its own word the device forwards whatever arrived on its chain input. A row of devices therefore reads as one long shift register: the first device's word comes first, then the next device's word, with no gap between them. All serial pins are sampled with the system clock, so the host's serial clock must be much slower than the system clock. The filter limits are parameters counted in system-clock cycles.

Top module: `serin_chip`

## Requirements
- R1: After reset is released (`rst_n` high), and while `cs_n` stays high, `sdo` reads 0.
- R2: `sdo` is 0 in every cycle that follows a cycle in which `cs_n` was sampled high, whatever `sclk` and `sdi` do.
- R3: On the clock edge that first sees `cs_n` low, the filtered input byte is frozen. It is shifted out MSB first, with `din[7]` first. Changes to `din` after that edge do not alter the word being read.
- R4: With `word8` low when `cs_n` falls, the word is 16 bits: the input byte, then a status byte. Status bit 2 is the inverse of `uv_alarm`, bit 1 equals `ot_alarm`, and bit 0 is the inverse of `uv_warn`. All three flags are frozen at the same edge as the inputs.
- R5: Status bits 7:3 hold a 5-bit check code of the frozen byte. The generator is x^5+x^4+x^2+1, bits are fed MSB first, and the code starts from zero.
- R6: With `word8` high when `cs_n` falls, the word is the input byte alone (8 bits). `word8` changes during a transfer take effect only at the next falling `cs_n`.
- R7: `sdi` is captured on each rising `sclk`. `sdo` changes only on a falling `sclk`. After the device's own 8 or 16 bits, `sdo` presents the captured `sdi` bits in arrival order.
- R8: `dly_sel` = 2'b00 applies no filtering: a new `din` level is taken one clock after it appears.
- R9: A `din` bit that differs from its filtered value on T consecutive clock edges is taken on the T-th edge. T is 1 for `dly_sel`=2'b00, `T_SHORT` for 2'b10, `T_MID` for 2'b01 and `T_LONG` for 2'b11.
- R10: A `din` pulse lasting fewer than T clock edges leaves the filtered value, and so the frozen byte, unchanged.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 8 | Raw digital inputs |
| dly_sel | input | 2 | Filter time select |
| word8 | input | 1 | 1: input byte only; 0: input byte plus status byte |
| uv_alarm | input | 1 | Undervoltage alarm, active high |
| ot_alarm | input | 1 | Overtemperature alarm, active high |
| uv_warn | input | 1 | Undervoltage warning, active high |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Chain input from the downstream device |
| sdo | output | 1 | Serial data output |

## Verification
A corrupted filter counter or filtered bit shows up only through the word frozen at the next chip-select fall. For that reason the filter limits are probed at exactly T-1 and T edges before that fall. A bad shift register, a bad capture bit or a wrong latched mode shows up at `sdo` within one serial bit period. It appears as a wrong bit, a bit appearing without a falling serial clock, or chain data arriving at the wrong position. Because the reference model is compared on every system clock, such errors are caught in the cycle they first reach `sdo`.

// File: rtl/serin_pkg.sv
package serin_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 5;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam logic [CRC_W-1:0] CRC_GEN = 5'h15;

  typedef enum logic [1:0] {
    DLY_NONE  = 2'b00,
    DLY_MID   = 2'b01,
    DLY_SHORT = 2'b10,
    DLY_LONG  = 2'b11
  } dly_code_e;

  function automatic logic [CRC_W-1:0] crc5(input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_GEN : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/serin_debounce.sv
module serin_debounce #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [CW-1:0] limit,
  output logic          filt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (raw != filt_q) begin
      if (cnt_q >= limit - CW'(1)) begin
        filt_d = raw;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/serin_status.sv
module serin_status
  import serin_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  input  logic              uv_alarm,
  input  logic              ot_alarm,
  input  logic              uv_warn,
  output logic [BYTE_W-1:0] status
);
  always_comb begin
    status = {crc5(data), ~uv_alarm, ot_alarm, ~uv_warn};
  end
endmodule

// File: rtl/serin_shifter.sv
module serin_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         half,
  input  logic         rise,
  input  logic         fall,
  input  logic         sdi,
  output logic         msb
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] sr_q, sr_d;
  logic         cap_q, cap_d;
  logic         half_q, half_d;

  always_comb begin
    sr_d   = sr_q;
    cap_d  = cap_q;
    half_d = half_q;
    if (load) begin
      sr_d   = word;
      half_d = half;
    end else if (fall) begin
      if (half_q) begin
        sr_d[W-1:HW] = {sr_q[W-2:HW], cap_q};
      end else begin
        sr_d = {sr_q[W-2:0], cap_q};
      end
    end
    if (rise) begin
      cap_d = sdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cap_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cap_q  <= cap_d;
      half_q <= half_d;
    end
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/serin_chip.sv
module serin_chip
  import serin_pkg::*;
#(
  parameter int unsigned T_SHORT = 3,
  parameter int unsigned T_MID   = 7,
  parameter int unsigned T_LONG  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  input  logic [1:0]        dly_sel,
  input  logic              word8,
  input  logic              uv_alarm,
  input  logic              ot_alarm,
  input  logic              uv_warn,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo
);
  localparam int unsigned CW = $clog2(T_LONG + 1);

  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rs2_q;

  logic [CW-1:0] limit;
  always_comb begin
    case (dly_code_e'(dly_sel))
      DLY_SHORT: limit = CW'(T_SHORT);
      DLY_MID:   limit = CW'(T_MID);
      DLY_LONG:  limit = CW'(T_LONG);
      default:   limit = CW'(1);
    endcase
  end

  logic [BYTE_W-1:0] filt;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_flt
    serin_debounce #(.CW(CW)) u_flt (
      .clk   (clk),
      .rst_n (rst_i_n),
      .raw   (din[i]),
      .limit (limit),
      .filt  (filt[i])
    );
  end

  logic [BYTE_W-1:0] status;
  serin_status u_stat (
    .data     (filt),
    .uv_alarm (uv_alarm),
    .ot_alarm (ot_alarm),
    .uv_warn  (uv_warn),
    .status   (status)
  );

  logic cs_q, sclk_q, cs_d, sclk_d;
  always_comb begin
    cs_d   = cs_n;
    sclk_d = sclk;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
    end
  end

  logic load, rise, fall;
  logic [WORD_W-1:0] word;
  always_comb begin
    load = cs_q & ~cs_n;
    rise = ~cs_q & ~sclk_q & sclk;
    fall = ~cs_q & sclk_q & ~sclk;
    word = word8 ? {filt, {BYTE_W{1'b0}}} : {filt, status};
  end

  logic msb;
  serin_shifter #(.W(WORD_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (load),
    .word  (word),
    .half  (word8),
    .rise  (rise),
    .fall  (fall),
    .sdi   (sdi),
    .msb   (msb)
  );

  assign sdo = ~cs_q & msb;
endmodule

// File: rtl/serin_chip_chk.sv
module serin_chip_chk
  import serin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              sdo,
  input logic              cs_q,
  input logic [BYTE_W-1:0] din,
  input logic [BYTE_W-1:0] filt
);
  // R2: deselected in the previous cycle means a quiet output
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !sdo);

  // R7: while selected, the output moves only after a falling serial clock
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n, 2) && !$past(cs_n) && !$stable(sdo))
      |-> ($past(sclk, 2) && !$past(sclk)));

  // R3: first bit after select falls is the frozen top input bit
  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_q) && !$past(cs_n)) |-> (sdo == $past(filt[BYTE_W-1])));

  // R9: a filtered bit only ever moves to the raw level it saw
  a_r9_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt ^ $past(filt)) & (filt ^ $past(din))) == '0);
endmodule

bind serin_chip serin_chip_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .sdo   (sdo),
  .cs_q  (cs_q),
  .din   (din),
  .filt  (filt)
);

// File: tb/tb_serin_chip.sv
module tb_serin_chip;
  localparam int TS = 3;
  localparam int TM = 7;
  localparam int TL = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] din;
  logic [1:0] dly_sel;
  logic word8, uv_alarm, ot_alarm, uv_warn, cs_n, sclk, sdi;
  logic sdo;

  always #10 clk = ~clk;

  serin_chip #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dly_sel(dly_sel), .word8(word8),
    .uv_alarm(uv_alarm), .ot_alarm(ot_alarm), .uv_warn(uv_warn),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] crc_ref(input logic [7:0] b);
    logic [7:0] t = b;
    for (int k = 0; k < 8; k++) t = t[7] ? ((t << 1) ^ 8'ha8) : (t << 1);
    return t[7:3];
  endfunction

  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'b10: return TS;
      2'b01: return TM;
      2'b11: return TL;
      default: return 1;
    endcase
  endfunction

  // behavioural reference model
  int rel;
  bit m_cs, m_sclk, m_cap;
  bit m_f[8];
  int m_cnt[8];
  bit q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_cs = 1; m_sclk = 0; m_cap = 0; q.delete();
      for (int i = 0; i < 8; i++) begin m_f[i] = 0; m_cnt[i] = 0; end
    end else if (rel < 2) begin
      rel++;
    end else begin
      if (m_cs && !cs_n) begin
        logic [7:0] fb;
        logic [7:0] st;
        for (int i = 0; i < 8; i++) fb[i] = m_f[i];
        st = {crc_ref(fb), !uv_alarm, ot_alarm, !uv_warn};
        q.delete();
        for (int i = 7; i >= 0; i--) q.push_back(fb[i]);
        if (!word8) for (int i = 7; i >= 0; i--) q.push_back(st[i]);
      end else if (!m_cs && m_sclk && !sclk) begin
        void'(q.pop_front());
        q.push_back(m_cap);
      end
      if (!m_cs && !m_sclk && sclk) m_cap = sdi;
      for (int i = 0; i < 8; i++) begin
        if (din[i] != m_f[i]) begin
          if (m_cnt[i] + 1 >= lim_of(dly_sel)) begin m_f[i] = din[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end else m_cnt[i] = 0;
      end
      m_cs = cs_n;
      m_sclk = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rel >= 2) begin
      bit e;
      e = !m_cs && q.size() > 0 && q[0];
      chk(sdo === e, "R7 per-cycle", {31'd0, sdo}, {31'd0, e});
    end
  end

  task automatic frame(input int n, input logic [31:0] chain, input bit disturb, output logic [31:0] got);
    got = '0;
    cs_n = 0;
    repeat (3) @(negedge clk);
    if (disturb) begin
      din = ~din; word8 = ~word8; uv_alarm = ~uv_alarm; ot_alarm = ~ot_alarm;
    end
    for (int i = 0; i < n; i++) begin
      got[n-1-i] = sdo;
      sdi = chain[n-1-i];
      sclk = 1;
      repeat (3) @(negedge clk);
      sclk = 0;
      repeat (3) @(negedge clk);
    end
    cs_n = 1;
    sdi = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle(input logic [1:0] s, input logic [7:0] v);
    dly_sel = s;
    din = v;
    repeat (30) @(negedge clk);
  endtask

  function automatic logic [7:0] stat(input logic [7:0] b, input bit uv, input bit ot, input bit w);
    return {crc_ref(b), !uv, ot, !w};
  endfunction

  logic [31:0] got;
  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; din = 0; dly_sel = 0; word8 = 0; uv_alarm = 0; ot_alarm = 0;
    uv_warn = 0; cs_n = 1; sclk = 0; sdi = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sdo === 1'b0, "R1 reset", {31'd0, sdo}, 0);

    // 16-bit word, no alarms, chain byte behind it
    settle(2'b00, 8'hA5);
    frame(24, 32'h00C30000, 0, got);
    chk(got[23:16] == 8'hA5, "R3 input byte", got[23:16], 8'hA5);
    chk(got[15:11] == crc_ref(8'hA5), "R5 check code", got[15:11], crc_ref(8'hA5));
    chk(got[10:8] == 3'b101, "R4 flags clear", got[10:8], 3'b101);
    chk(got[7:0] == 8'hC3, "R7 chain byte", got[7:0], 8'hC3);

    // all alarms set
    uv_alarm = 1; ot_alarm = 1; uv_warn = 1;
    settle(2'b00, 8'h3C);
    frame(24, 32'h00010000, 0, got);
    chk(got[23:8] == {8'h3C, stat(8'h3C, 1, 1, 1)}, "R4 alarms", got[23:8], {8'h3C, stat(8'h3C, 1, 1, 1)});
    chk(got[7:0] == 8'h01, "R7 chain after alarms", got[7:0], 8'h01);
    uv_alarm = 0; ot_alarm = 0; uv_warn = 0;

    // 8-bit mode
    word8 = 1;
    settle(2'b00, 8'h96);
    frame(16, 32'h00005A00, 0, got);
    chk(got[15:0] == 16'h965A, "R6 byte only", got[15:0], 16'h965A);

    // disturb inputs and mode after the freeze
    word8 = 0;
    settle(2'b00, 8'h81);
    frame(24, 32'h00000000, 1, got);
    chk(got[23:8] == {8'h81, stat(8'h81, 0, 0, 0)}, "R3 R6 frozen word", got[23:8], {8'h81, stat(8'h81, 0, 0, 0)});
    chk(got[7:0] == 8'h00, "R6 mode held in frame", got[7:0], 8'h00);
    word8 = 1; uv_alarm = 0; ot_alarm = 0;

    // idle with serial clock activity
    repeat (4) begin
      sclk = 1; sdi = 1; @(negedge clk);
      chk(sdo === 1'b0, "R2 idle", {31'd0, sdo}, 0);
      sclk = 0; @(negedge clk);
    end
    sdi = 0;

    // filter boundaries: T-1 edges keep old, T edges take new
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = lim_of(2'(s));
      settle(2'(s), 8'h00);
      din = 8'hFF;
      repeat (lim - 1) @(negedge clk);
      frame(8, 0, 0, got);
      chk(got[7:0] == 8'h00, (s == 0) ? "R8 no filter early" : "R10 short pulse", got[7:0], 8'h00);
      settle(2'(s), 8'h00);
      din = 8'hFF;
      repeat (lim) @(negedge clk);
      frame(8, 0, 0, got);
      chk(got[7:0] == 8'hFF, (s == 0) ? "R8 no filter" : "R9 limit reached", got[7:0], 8'hFF);
    end

    // glitch shorter than the long limit, then restored
    settle(2'b11, 8'h0F);
    din = 8'hF0;
    repeat (TL - 2) @(negedge clk);
    din = 8'h0F;
    repeat (2) @(negedge clk);
    frame(8, 0, 0, got);
    chk(got[7:0] == 8'h0F, "R10 glitch", got[7:0], 8'h0F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule